// File: doc/BRIEF.md
# Ripple Adder-Subtractor with Increment and Decrement

This block is a purely combinational two's-complement arithmetic unit of parameterised width. A single chain of full-adder cells serves all four operations. The operation select only conditions the second operand and the chain's initial carry.

For subtraction, every bit of B is inverted and the initial carry is set to one. For increment, B is forced to zero and the initial carry is set to one. For decrement, B is forced to all ones and the initial carry is zero.

The carry travels strictly from bit 0 upward, and each cell sees only its own operand bits and the carry from the bit below. Because the operands are plain combinational inputs with no flow, there is no valid/ready handshake. A result is valid whenever the inputs have been stable for the chain's settling time.

Top module: `addsub_unit`

## Requirements
- R1: With op_i = 2'b00, sum_o equals (a_i + b_i) mod 2^WIDTH and carry_o is the unsigned carry out of the top bit.
- R2: With op_i = 2'b01, sum_o equals (a_i - b_i) mod 2^WIDTH and carry_o is 1 exactly when a_i >= b_i taken as unsigned values (no borrow).
- R3: With op_i = 2'b10, sum_o equals (a_i + 1) mod 2^WIDTH. carry_o is 1 only when a_i is all ones. b_i has no effect on any output.
- R4: With op_i = 2'b11, sum_o equals (a_i - 1) mod 2^WIDTH. carry_o is 0 only when a_i is zero. b_i has no effect on any output.
- R5: ovf_o is 1 exactly when the carry into the top cell differs from the carry out of it. This is the case when the two's-complement result of the operation does not fit in WIDTH bits.
- R6: All outputs are combinational functions of a_i, b_i and op_i, with no clock and no stored state.
- R7: Zero operands under add give a zero sum, no carry and no overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand (ignored for increment and decrement) |
| op_i | input | 2 | Operation: 00 add, 01 subtract, 10 increment, 11 decrement |
| sum_o | output | WIDTH | Result modulo 2^WIDTH |
| carry_o | output | 1 | Carry out of the top cell |
| ovf_o | output | 1 | Signed overflow |

## Verification
The assertions are immediate checks in combinational blocks. They assume the inputs hold known values once evaluated, so they skip any evaluation in which a_i, b_i or op_i carries an unknown bit. The bench drives all inputs to zero from time zero and writes only fully defined values, taken from $urandom or from directed corners. It changes the inputs away from the sampling point, so every check sees a settled chain.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_INC = 2'b10,
    OP_DEC = 2'b11
  } arith_op_e;
endpackage

// File: rtl/fa_cell.sv
module fa_cell (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic half;
  always_comb begin
    half = x_i ^ y_i;
    s_o  = half ^ c_i;
    c_o  = (x_i & y_i) | (c_i & half);
  end
endmodule

// File: rtl/operand_cond.sv
module operand_cond #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       op_i,
  output logic [WIDTH-1:0] b_eff_o,
  output logic             cin_o
);
  import addsub_pkg::*;
  arith_op_e op;
  logic      invert;
  logic      force_const;
  logic      const_bit;

  always_comb begin
    op          = arith_op_e'(op_i);
    invert      = (op == OP_SUB);
    force_const = op_i[1];
    const_bit   = (op == OP_DEC);
    cin_o       = (op == OP_SUB) || (op == OP_INC);
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bsel
    assign b_eff_o[i] = force_const ? const_bit : (b_i[i] ^ invert);
  end
endmodule

// File: rtl/ripple_chain.sv
module ripple_chain #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             cmsb_o
);
  logic [WIDTH:0] carry;
  assign carry[0] = cin_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    fa_cell u_fa (
      .x_i (a_i[i]),
      .y_i (b_i[i]),
      .c_i (carry[i]),
      .s_o (sum_o[i]),
      .c_o (carry[i+1])
    );
  end

  assign cout_o = carry[WIDTH];
  assign cmsb_o = carry[WIDTH-1];

  // R1: the cell chain must agree with a wide arithmetic sum of its own inputs
  always_comb begin
    if (!$isunknown({a_i, b_i, cin_i}))
      a_r1_chain_sum: assert ({cout_o, sum_o} ==
        ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}));
  end
endmodule

// File: rtl/addsub_unit.sv
module addsub_unit #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       op_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o,
  output logic             ovf_o
);
  import addsub_pkg::*;
  localparam int MSB = WIDTH - 1;
  localparam logic [WIDTH-1:0] ONE   = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] ZERO  = '0;
  localparam logic [WIDTH-1:0] ONES  = '1;

  logic [WIDTH-1:0] b_eff;
  logic             cin;
  logic             c_msb;

  operand_cond #(.WIDTH(WIDTH)) u_cond (
    .b_i     (b_i),
    .op_i    (op_i),
    .b_eff_o (b_eff),
    .cin_o   (cin)
  );

  ripple_chain #(.WIDTH(WIDTH)) u_chain (
    .a_i    (a_i),
    .b_i    (b_eff),
    .cin_i  (cin),
    .sum_o  (sum_o),
    .cout_o (carry_o),
    .cmsb_o (c_msb)
  );

  assign ovf_o = carry_o ^ c_msb;

  always_comb begin
    if (!$isunknown({a_i, b_i, op_i})) begin
      case (op_i)
        2'b01: begin
          a_r2_sub_result: assert (sum_o == a_i - b_i);
          a_r2_no_borrow:  assert (carry_o == (a_i >= b_i));
        end
        2'b10: begin
          a_r3_inc_result: assert (sum_o == a_i + ONE);
          a_r3_inc_carry:  assert (carry_o == (a_i == ONES));
        end
        2'b11: begin
          a_r4_dec_result: assert (sum_o == a_i - ONE);
          a_r4_dec_carry:  assert (carry_o == (a_i != ZERO));
        end
        default: begin
          a_r1_add_result: assert (sum_o == a_i + b_i);
        end
      endcase
      // R5: overflow agrees with the sign rule on the conditioned operands
      a_r5_overflow: assert (ovf_o ==
        ((a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB])));
    end
  end
endmodule

// File: tb/sim_addsub_unit.sv
module sim_addsub_unit;
  localparam int W = 32;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a = '0, b = '0;
  logic [1:0]   op = 2'b00;
  logic [W-1:0] sum;
  logic         cy, ov;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  addsub_unit #(.WIDTH(W)) u0 (
    .a_i(a), .b_i(b), .op_i(op), .sum_o(sum), .carry_o(cy), .ovf_o(ov)
  );

  function automatic logic [W+1:0] model(input logic [W-1:0] x, input logic [W-1:0] y,
                                         input logic [1:0] o);
    logic [W-1:0] yy;
    logic         ci;
    logic [W:0]   full;
    logic         sv;
    case (o)
      2'b00: begin yy = y;  ci = 1'b0; end
      2'b01: begin yy = ~y; ci = 1'b1; end
      2'b10: begin yy = '0; ci = 1'b1; end
      default: begin yy = '1; ci = 1'b0; end
    endcase
    full = {1'b0, x} + {1'b0, yy} + {{W{1'b0}}, ci};
    sv   = (x[W-1] == yy[W-1]) && (full[W-1] != x[W-1]);
    return {sv, full};
  endfunction

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y,
                       input logic [1:0] o, input string req);
    logic [W+1:0] e;
    @(negedge clk);
    a = x; b = y; op = o;
    #1;
    e = model(x, y, o);
    checks++;
    if ({ov, cy, sum} !== e) begin
      errors++;
      $display("FAIL %s op=%b a=%h b=%h : got ovf=%b c=%b s=%h exp ovf=%b c=%b s=%h",
               req, o, x, y, ov, cy, sum, e[W+1], e[W], e[W-1:0]);
    end
  endtask

  task automatic expect_lit(input logic [W-1:0] s, input logic c, input logic v, input string req);
    checks++;
    if ({v, c, s} !== {ov, cy, sum}) begin
      errors++;
      $display("FAIL %s : got ovf=%b c=%b s=%h exp ovf=%b c=%b s=%h", req, ov, cy, sum, v, c, s);
    end
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    expect_lit('0, 1'b0, 1'b0, "R7 zero under reset");
    rst = 1'b0;
    // directed corners
    apply(32'h0000_0005, 32'h0000_0003, 2'b00, "R1");
    expect_lit(32'h8, 1'b0, 1'b0, "R1 5+3");
    apply(32'hFFFF_FFFF, 32'h0000_0001, 2'b00, "R1 carry");
    expect_lit(32'h0, 1'b1, 1'b0, "R1 wrap carry");
    apply(32'h7FFF_FFFF, 32'h0000_0001, 2'b00, "R5 add ovf");
    expect_lit(32'h8000_0000, 1'b0, 1'b1, "R5 pos overflow");
    apply(32'h0000_0003, 32'h0000_0005, 2'b01, "R2 borrow");
    expect_lit(32'hFFFF_FFFE, 1'b0, 1'b0, "R2 3-5");
    apply(32'h0000_0009, 32'h0000_0009, 2'b01, "R2 equal");
    expect_lit(32'h0, 1'b1, 1'b0, "R2 equal no borrow");
    apply(32'h8000_0000, 32'h0000_0001, 2'b01, "R5 sub ovf");
    expect_lit(32'h7FFF_FFFF, 1'b1, 1'b1, "R5 neg overflow");
    apply(32'hFFFF_FFFF, 32'h1234_5678, 2'b10, "R3 inc wrap");
    expect_lit(32'h0, 1'b1, 1'b0, "R3 all ones +1");
    apply(32'h7FFF_FFFF, 32'hDEAD_BEEF, 2'b10, "R3 inc ovf");
    expect_lit(32'h8000_0000, 1'b0, 1'b1, "R3 R5 inc overflow");
    apply(32'h0000_0000, 32'hCAFE_0000, 2'b11, "R4 dec zero");
    expect_lit(32'hFFFF_FFFF, 1'b0, 1'b0, "R4 0-1");
    apply(32'h8000_0000, 32'h0000_0000, 2'b11, "R4 dec ovf");
    expect_lit(32'h7FFF_FFFF, 1'b1, 1'b1, "R4 R5 dec overflow");
    // R3/R4: b has no effect
    for (int k = 0; k < 20; k++) begin
      logic [W-1:0] ra;
      logic [W-1:0] s1;
      ra = $urandom;
      apply(ra, $urandom, 2'b10, "R3 b ignored");
      s1 = sum;
      apply(ra, $urandom, 2'b10, "R3 b ignored");
      checks++;
      if (sum !== s1) begin errors++; $display("FAIL R3 b changed inc: got %h exp %h", sum, s1); end
      apply(ra, $urandom, 2'b11, "R4 b ignored");
    end
    // R6: output follows input with no clock edge in between
    @(negedge clk);
    a = 32'd10; b = 32'd20; op = 2'b00; #0.5;
    b = 32'd30; #0.5;
    expect_lit(32'd40, 1'b0, 1'b0, "R6 combinational update");
    // constrained random, biased toward sign boundaries
    for (int k = 0; k < 2000; k++) begin
      logic [W-1:0] ra, rb;
      ra = $urandom; rb = $urandom;
      if (k % 7 == 0) ra = {ra[W-1], {(W-1){~ra[W-1]}}};
      if (k % 11 == 0) rb = '1;
      apply(ra, rb, 2'($urandom), "R1 R2 R3 R4 R5 random");
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule